// File: doc/BRIEF.md
# ISDN B/D channel frame packer

This block connects a serial line port, carrying two 64 Kbps bearer channels (B1, B2) and one 16 Kbps signalling channel (D), to a 32-bit host register interface. On the line, each 8 kHz frame holds 18 bits: eight B1 bits, then eight B2 bits, then two D bits, each field sent most significant bit first. A frame-sync pulse marks the first bit of each frame. A one-cycle bit strobe marks each bit period. Both come from an external timing unit.

On receive, every channel is shifted into a small shift register. Each completed byte is placed in a shadow register at the slot chosen by a 2-bit frame counter. After four frames (a 2 kHz period), the shadows are copied into the host-visible words in one step, and a single interrupt is raised for both directions. On transmit, the host writes a B1 word, a B2 word and a D byte into holding registers. These move into transmit shadows at the next 2 kHz transfer. A multiplexer then picks one byte (and one D pair) per frame into a frame shift register that drives the line.

Top module: `isdn_frame_packer`

## Requirements
- R1: After reset, irq and rx_overrun are 0, rx_b1_data and rx_b2_data read 32'hFFFFFFFF, rx_d_data reads 8'hFF, and line_out is 1.
- R2: A bit strobe with fsync high is bit 0 of a frame; bits 0-7 are B1, 8-15 are B2 and 16-17 are D, each MSB first. Strobes after bit 17 and before the next fsync, or before the first fsync, are ignored on both line_in and line_out.
- R3: A 2-bit frame counter starts at 0 after reset and advances once at the end of every frame. Frame k (k = 0..3) of a group occupies bits [31-8k:24-8k] of the B words and bits [7-2k:6-2k] of the D byte.
- R4: rx_b1_data, rx_b2_data and rx_d_data change only at the end of the frame where the counter is 3. The new values are visible in the cycle after that last strobe.
- R5: irq is set at each 2 kHz transfer and stays set until an irq_clr pulse. A transfer in the same cycle as irq_clr wins.
- R6: A transfer that happens while the previous receive words have not been acknowledged by rx_rd sets rx_overrun. rx_overrun is cleared by irq_clr.
- R7: A host write with tx_wr is taken into the transmit shadows at the next transfer. In the following group, frame k sends byte k of each B word and D pair k, using the same positions as R3.
- R8: If no host write arrives before a transfer, the transmit shadows keep their contents, and the previous words are sent again. Until the first write, every transmitted bit is 1.
- R9: line_out changes only in the cycle after a bit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per line bit |
| fsync | input | 1 | Marks the strobe of bit 0 of a frame |
| line_in | input | 1 | Received line bit, valid with bit_tick |
| line_out | output | 1 | Transmitted line bit for the current bit period |
| tx_wr | input | 1 | Host write strobe for the transmit words |
| tx_b1_data | input | 32 | Transmit B1 word, four frames |
| tx_b2_data | input | 32 | Transmit B2 word, four frames |
| tx_d_data | input | 8 | Transmit D byte, four frames |
| rx_rd | input | 1 | Host acknowledge of the receive words |
| irq_clr | input | 1 | Clears irq and rx_overrun |
| rx_b1_data | output | 32 | Received B1 word |
| rx_b2_data | output | 32 | Received B2 word |
| rx_d_data | output | 8 | Received D byte |
| irq | output | 1 | Common 2 kHz interrupt |
| rx_overrun | output | 1 | Receive words overwritten unread |

## Verification
The assertions watch the following on every cycle:
- the receive words stay unchanged except at a transfer;
- irq is set, held and cleared exactly by transfer and clear;
- the overrun condition;
- the frame counter's step;
- line_out moving only after a strobe.

Only the bench scenarios can show that bits land in the right byte and pair slots in both directions. The same holds for three other behaviours:
- a host write takes effect one group later;
- old transmit words repeat when no write arrives;
- stray strobes outside a frame leave the data path untouched.

// File: rtl/isdn_frame_packer.sv
module isdn_frame_packer #(
  parameter int BW     = 8,
  parameter int FRAMES = 4,
  parameter int DBITS  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bit_tick,
  input  logic                    fsync,
  input  logic                    line_in,
  output logic                    line_out,
  input  logic                    tx_wr,
  input  logic [BW*FRAMES-1:0]    tx_b1_data,
  input  logic [BW*FRAMES-1:0]    tx_b2_data,
  input  logic [DBITS*FRAMES-1:0] tx_d_data,
  input  logic                    rx_rd,
  input  logic                    irq_clr,
  output logic [BW*FRAMES-1:0]    rx_b1_data,
  output logic [BW*FRAMES-1:0]    rx_b2_data,
  output logic [DBITS*FRAMES-1:0] rx_d_data,
  output logic                    irq,
  output logic                    rx_overrun
);
  localparam int WW = BW*FRAMES;
  localparam int DW = DBITS*FRAMES;
  localparam int FB = 2*BW + DBITS;
  localparam int PW = $clog2(FB+1);
  localparam int SW = $clog2(FRAMES);   // FRAMES is a power of two

  logic [PW-1:0] pos, cur;
  logic [SW-1:0] slot, nslot;
  logic          tick_ok, frame_end, xfer;

  assign cur       = fsync ? '0 : pos;
  assign tick_ok   = bit_tick && (fsync || pos < PW'(FB));
  assign frame_end = tick_ok && cur == PW'(FB-1);
  assign xfer      = frame_end && slot == SW'(FRAMES-1);
  assign nslot     = slot + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos  <= PW'(FB);
      slot <= '0;
    end else if (tick_ok) begin
      pos <= cur + 1'b1;
      if (frame_end) slot <= nslot;
    end
  end

  // receive path
  logic [BW-1:0]    rx_b1_sr, rx_b2_sr, b1_in, b2_in;
  logic [DBITS-1:0] rx_d_sr, d_in;
  logic [WW-1:0]    rx_sh_b1, rx_sh_b2;
  logic [DW-1:0]    rx_sh_d, d_sh_nxt;
  logic             rx_unread;

  assign b1_in = BW'({rx_b1_sr, line_in});
  assign b2_in = BW'({rx_b2_sr, line_in});
  assign d_in  = DBITS'({rx_d_sr, line_in});

  always_comb begin
    d_sh_nxt = rx_sh_d;
    d_sh_nxt[(FRAMES-1-int'(slot))*DBITS +: DBITS] = d_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_b1_sr <= '1;
      rx_b2_sr <= '1;
      rx_d_sr  <= '1;
      rx_sh_b1 <= '1;
      rx_sh_b2 <= '1;
      rx_sh_d  <= '1;
    end else if (tick_ok) begin
      if (cur < PW'(BW))        rx_b1_sr <= b1_in;
      else if (cur < PW'(2*BW)) rx_b2_sr <= b2_in;
      else                      rx_d_sr  <= d_in;
      if (cur == PW'(BW-1))   rx_sh_b1[(FRAMES-1-int'(slot))*BW +: BW] <= b1_in;
      if (cur == PW'(2*BW-1)) rx_sh_b2[(FRAMES-1-int'(slot))*BW +: BW] <= b2_in;
      if (frame_end)          rx_sh_d <= d_sh_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_b1_data <= '1;
      rx_b2_data <= '1;
      rx_d_data  <= '1;
      rx_unread  <= 1'b0;
      rx_overrun <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (xfer) begin
        rx_b1_data <= rx_sh_b1;
        rx_b2_data <= rx_sh_b2;
        rx_d_data  <= d_sh_nxt;
      end
      if (xfer)       rx_unread <= 1'b1;
      else if (rx_rd) rx_unread <= 1'b0;
      if (xfer && rx_unread && !rx_rd) rx_overrun <= 1'b1;
      else if (irq_clr)                rx_overrun <= 1'b0;
      if (xfer)         irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  // transmit path
  logic [WW-1:0] tx_hold_b1, tx_hold_b2, tx_sh_b1, tx_sh_b2, nx_b1, nx_b2;
  logic [DW-1:0] tx_hold_d, tx_sh_d, nx_d;
  logic          tx_pend, load_sh;
  logic [FB-1:0] tx_sr, nx_frame;

  assign load_sh  = xfer && tx_pend;
  assign nx_b1    = load_sh ? tx_hold_b1 : tx_sh_b1;
  assign nx_b2    = load_sh ? tx_hold_b2 : tx_sh_b2;
  assign nx_d     = load_sh ? tx_hold_d  : tx_sh_d;
  assign nx_frame = {nx_b1[(FRAMES-1-int'(nslot))*BW +: BW],
                     nx_b2[(FRAMES-1-int'(nslot))*BW +: BW],
                     nx_d[(FRAMES-1-int'(nslot))*DBITS +: DBITS]};
  assign line_out = tx_sr[FB-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_hold_b1 <= '1;
      tx_hold_b2 <= '1;
      tx_hold_d  <= '1;
      tx_pend    <= 1'b0;
      tx_sh_b1   <= '1;
      tx_sh_b2   <= '1;
      tx_sh_d    <= '1;
      tx_sr      <= '1;
    end else begin
      if (tx_wr) begin
        tx_hold_b1 <= tx_b1_data;
        tx_hold_b2 <= tx_b2_data;
        tx_hold_d  <= tx_d_data;
        tx_pend    <= 1'b1;
      end else if (xfer) begin
        tx_pend <= 1'b0;
      end
      if (load_sh) begin
        tx_sh_b1 <= tx_hold_b1;
        tx_sh_b2 <= tx_hold_b2;
        tx_sh_d  <= tx_hold_d;
      end
      if (tick_ok) tx_sr <= frame_end ? nx_frame : {tx_sr[FB-2:0], 1'b1};
    end
  end
endmodule

// File: rtl/isdn_frame_packer_chk.sv
module isdn_frame_packer_chk #(
  parameter int SW = 2,
  parameter int WW = 32,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_tick,
  input logic          irq_clr,
  input logic          rx_rd,
  input logic          line_out,
  input logic          irq,
  input logic          rx_overrun,
  input logic [WW-1:0] rx_b1_data,
  input logic [DW-1:0] rx_d_data,
  input logic          xfer,
  input logic          frame_end,
  input logic          rx_unread,
  input logic [SW-1:0] slot
);
  AST_RX_ONLY_AT_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(rx_b1_data) && $stable(rx_d_data));                 // R4
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> irq);                                                         // R5
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);                                              // R5
  AST_IRQ_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !irq && !xfer |=> !irq);                                               // R5
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && rx_unread && !rx_rd |=> rx_overrun);                           // R6
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> slot == SW'($past(slot) + 1'b1));                        // R3
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(slot));                                         // R3
  AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(line_out));                                      // R9
endmodule

bind isdn_frame_packer isdn_frame_packer_chk #(.SW(SW), .WW(WW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .irq_clr(irq_clr), .rx_rd(rx_rd),
  .line_out(line_out), .irq(irq), .rx_overrun(rx_overrun), .rx_b1_data(rx_b1_data),
  .rx_d_data(rx_d_data), .xfer(xfer), .frame_end(frame_end), .rx_unread(rx_unread),
  .slot(slot));

// File: tb/isdn_frame_packer_bench.sv
module isdn_frame_packer_bench;
  logic clk = 0, rst_n = 0, bit_tick = 0, fsync = 0, line_in = 0;
  logic tx_wr = 0, rx_rd = 0, irq_clr = 0;
  logic [31:0] tx_b1_data = 0, tx_b2_data = 0;
  logic [7:0]  tx_d_data = 0;
  logic line_out, irq, rx_overrun;
  logic [31:0] rx_b1_data, rx_b2_data;
  logic [7:0]  rx_d_data;

  isdn_frame_packer u_isdn_frame_packer (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0, stray = 0;
  bit exp_q[$];

  // bench model
  int m_fc = 0;
  bit m_pend = 0, m_unread = 0, m_ovr = 0, m_irq = 0;
  logic [31:0] m_h1 = '1, m_h2 = '1, m_s1 = '1, m_s2 = '1;
  logic [7:0]  m_hd = '1, m_sd = '1;
  logic [31:0] m_r1 = '1, m_r2 = '1, a1, a2;
  logic [7:0]  m_rd = '1, ad;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] tx_frame(int k);
    return {m_s1[(3-k)*8 +: 8], m_s2[(3-k)*8 +: 8], m_sd[(3-k)*2 +: 2]};
  endfunction

  // monitor: pops one expected line bit per in-frame strobe
  always @(negedge clk) begin
    #2;
    if (bit_tick && !stray && rst_n) begin
      if (exp_q.size() == 0) chk("R7 queue", 1, 0);
      else chk("R7 line_out", line_out, exp_q.pop_front());
    end
  end

  task automatic send_frame(logic [7:0] b1, logic [7:0] b2, logic [1:0] d);
    logic [17:0] rx = {b1, b2, d};
    logic [17:0] tx = tx_frame(m_fc);
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      fsync = (i == 0); bit_tick = 1; line_in = rx[17-i];
      exp_q.push_back(tx[17-i]);
    end
    @(negedge clk);
    bit_tick = 0; fsync = 0;
    a1[(3-m_fc)*8 +: 8] = b1; a2[(3-m_fc)*8 +: 8] = b2; ad[(3-m_fc)*2 +: 2] = d;
    if (m_fc == 3) begin
      m_fc = 0;
      if (m_pend) begin m_s1 = m_h1; m_s2 = m_h2; m_sd = m_hd; m_pend = 0; end
      if (m_unread) m_ovr = 1;
      m_unread = 1; m_irq = 1;
      m_r1 = a1; m_r2 = a2; m_rd = ad;
    end else m_fc++;
  endtask

  task automatic stray_ticks(int n);
    logic lo = line_out;
    stray = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1; line_in = i[0];
    end
    @(negedge clk); bit_tick = 0;
    stray = 0;
    chk("R2 stray ticks line_out", line_out, lo);
    chk("R2 stray ticks next bit", line_out, tx_frame(m_fc)[17]);
  endtask

  task automatic send_group(int g, int stray_after);
    for (int k = 0; k < 4; k++) begin
      send_frame(8'(g*37 + k*11) ^ 8'h5A, 8'(g*53 + k*29) ^ 8'hC3, 2'(g + k));
      if (k == stray_after) stray_ticks(5);
      if (k < 3) begin
        chk("R4 rx_b1 held mid-group", rx_b1_data, m_r1);
        chk("R4 rx_d held mid-group", {24'd0, rx_d_data}, {24'd0, m_rd});
      end
    end
    chk("R3 rx_b1 packed", rx_b1_data, m_r1);
    chk("R3 rx_b2 packed", rx_b2_data, m_r2);
    chk("R3 rx_d packed", {24'd0, rx_d_data}, {24'd0, m_rd});
    chk("R5 irq set", {31'd0, irq}, {31'd0, m_irq});
    chk("R6 overrun", {31'd0, rx_overrun}, {31'd0, m_ovr});
  endtask

  task automatic host_write(logic [31:0] w1, logic [31:0] w2, logic [7:0] wd);
    @(negedge clk); tx_wr = 1; tx_b1_data = w1; tx_b2_data = w2; tx_d_data = wd;
    @(negedge clk); tx_wr = 0;
    m_h1 = w1; m_h2 = w2; m_hd = wd; m_pend = 1;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0; m_unread = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
    m_irq = 0; m_ovr = 0;
    chk("R5 irq cleared", {31'd0, irq}, 32'd0);
    chk("R6 overrun cleared", {31'd0, rx_overrun}, 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    a1 = '1; a2 = '1; ad = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 overrun", {31'd0, rx_overrun}, 32'd0);
    chk("R1 rx_b1", rx_b1_data, 32'hFFFFFFFF);
    chk("R1 rx_b2", rx_b2_data, 32'hFFFFFFFF);
    chk("R1 rx_d", {24'd0, rx_d_data}, 32'h000000FF);
    chk("R1 line_out", {31'd0, line_out}, 32'd1);
    stray_ticks(4);                     // R2: before the first fsync
    send_group(1, -1);                  // R8: all ones sent before any write
    host_write(32'hA1B2C3D4, 32'h0F1E2D3C, 8'b10_01_11_00);
    pulse_rd();
    pulse_clr();
    send_group(2, -1);                  // R7: write not yet in use
    send_group(3, -1);                  // R7 sends written words; R6 overrun (no read)
    send_group(4, 1);                   // R8 repeat; R2 stray ticks mid-group
    pulse_clr();
    pulse_rd();
    send_frame(8'h00, 8'hFF, 2'b01);
    host_write(32'h12345678, 32'h9ABCDEF0, 8'b00_11_01_10);
    send_frame(8'h81, 8'h7E, 2'b10);
    send_frame(8'hF0, 8'h0F, 2'b11);
    send_frame(8'h3C, 8'hC3, 2'b00);    // R8: old words until this transfer
    chk("R6 no overrun after read", {31'd0, rx_overrun}, 32'd0);
    send_group(6, -1);                  // R7: second written words
    chk("R7 all line bits consumed", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule